// File: doc/BRIEF.md
# Mode-Configurable Direct-Mapped Copy-Back Cache

This block sits between a processor port and an on-chip DRAM port. Both ports move whole 128-bit lines. It keeps a direct-mapped line store of 256 lines of 16 bytes each (4 KB). Stores are held in the cache and reach DRAM only when a dirty line is evicted. A control register, reached through the processor port at a fixed address, selects the operating mode at run time: unified instruction-and-data caching, instruction-only caching, or cache off. The same register can also request a purge, which writes back every dirty line and then invalidates the whole store.

A second requester, an external bus master, can also reach DRAM through the block. When its address is already cached, it is served from the line. When the address is not cached, the access goes straight to DRAM and no line is allocated or replaced.

Any address above the 2 MB DRAM window bypasses the cache in every mode. These accesses go out on the same memory port, where the outside logic steers them to external space.

In instruction-only and cache-off modes, an access that does not allocate still uses a line it hits. This keeps every requester's view of memory consistent.

Top module: `mcache_ctrl`

## Requirements
- R1: After reset, a read of the control register returns 0x01 (cache-off mode), and the memory port is idle.
- R2: The control register sits at address CTRL_ADDR. Bits [1:0] hold the mode: 01 is off, 10 is unified, 11 is instruction-only, and a write of 00 leaves the mode as it was. Bit 7 requests a purge. Bits 6:2 always read 0.
- R3: A line is 16 bytes. The line index is address bits [IDX_W+3:4], and the tag is the bits above the index up to bit 20. Two addresses that share an index but differ in tag evict each other, while addresses with different indexes coexist.
- R4: In unified mode, a processor read miss fills the line with exactly one DRAM read. A repeat read of that line hits and makes no DRAM transaction.
- R5: A write hit changes only the cached line and makes no DRAM write. When a dirty line is evicted, it is written to DRAM once before the new line is read.
- R6: In instruction-only mode, instruction fetches allocate lines. A data access that misses goes directly to DRAM without allocating. A data access that hits is served from the line, and a data write hit updates the line.
- R7: In cache-off mode, a processor access that misses goes directly to DRAM every time and allocates nothing.
- R8: Writing 1 to bit 7 writes every valid dirty line back to DRAM and invalidates all lines. The processor's ready is held off until this finishes, and bit 7 then reads 0.
- R9: An external-master read that hits returns the cached (possibly dirty) data with no DRAM transaction. An external-master write hit updates the line with no DRAM transaction.
- R10: An external-master miss makes exactly one direct DRAM transaction for its own line. It never writes back a victim and never allocates a line, so a line that was already cached stays resident.
- R11: A processor access at or above the 2 MB DRAM window makes exactly one memory-port transaction per access in every mode and never allocates.
- R12: A requester holds its request until a one-cycle ready pulse. When both requesters ask in the same cycle, the external master is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | Processor write |
| cpu_ifetch | input | 1 | Processor access is an instruction fetch |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wdata | input | DATA_W | Processor write line |
| cpu_ready | output | 1 | One-cycle completion pulse to the processor |
| cpu_rdata | output | DATA_W | Processor read line (valid with cpu_ready) |
| xm_req | input | 1 | External master request, held until xm_ready |
| xm_we | input | 1 | External master write |
| xm_addr | input | ADDR_W | External master byte address |
| xm_wdata | input | DATA_W | External master write line |
| xm_ready | output | 1 | One-cycle completion pulse to the external master |
| xm_rdata | output | DATA_W | External master read line (valid with xm_ready) |
| mem_req | output | 1 | Memory-port request, held until mem_ack |
| mem_we | output | 1 | Memory-port write |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | DATA_W | Memory write line |
| mem_ack | input | 1 | One-cycle memory completion |
| mem_rdata | input | DATA_W | Memory read line (valid with mem_ack) |

## Verification
The bench builds the block with LINES set to 16 and leaves the DRAM window and line width at their defaults. With this setting the index is address bits [7:4], so addresses 256 bytes apart conflict on one line. A purge then scans only 16 entries, and hit, conflict, victim write-back and non-allocation can all be shown with a handful of addresses. The bench counts memory-port reads and writes around each access and compares them with the DRAM contents it models. This tells hits apart from direct accesses and from allocating misses, and catches write-backs that happen too early.

// File: rtl/mcache_pkg.sv
package mcache_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_WBACK,
        S_FILL,
        S_DIRECT,
        S_PSCAN,
        S_PWB
    } state_e;

    localparam logic [1:0] M_KEEP    = 2'b00;
    localparam logic [1:0] M_OFF     = 2'b01;
    localparam logic [1:0] M_UNIFIED = 2'b10;
    localparam logic [1:0] M_INSTR   = 2'b11;

    localparam int PURGE_BIT = 7;
endpackage

// File: rtl/mcache_addr_dec.sv
module mcache_addr_dec #(
    parameter int ADDR_W = 32,
    parameter int OFF_W = 4,
    parameter int IDX_W = 8,
    parameter int TAG_W = 9,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag,
    output logic              in_dram,
    output logic              is_ctrl
);
    localparam int WIN_W = OFF_W + IDX_W + TAG_W;

    assign idx     = addr[OFF_W +: IDX_W];
    assign tag     = addr[OFF_W + IDX_W +: TAG_W];
    assign in_dram = (addr[ADDR_W-1:WIN_W] == '0);
    assign is_ctrl = (addr == CTRL_ADDR);
endmodule

// File: rtl/mcache_store.sv
module mcache_store #(
    parameter int LINES = 256,
    parameter int IDX_W = 8,
    parameter int TAG_W = 9,
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic              rd_dirty,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] data_q  [LINES];
    logic [TAG_W-1:0]  tag_q   [LINES];
    logic [LINES-1:0]  valid_q;
    logic [LINES-1:0]  dirty_q;

    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_data;
            tag_q[wr_idx]  <= wr_tag;
        end
    end
endmodule

// File: rtl/mcache_ctrl.sv
module mcache_ctrl
    import mcache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 128,
    parameter int LINES = 256,
    parameter int DRAM_AW = 21,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 32'hFFFF_FFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_ifetch,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              xm_req,
    input  logic              xm_we,
    input  logic [ADDR_W-1:0] xm_addr,
    input  logic [DATA_W-1:0] xm_wdata,
    output logic              xm_ready,
    output logic [DATA_W-1:0] xm_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = DRAM_AW - IDX_W - OFF_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

    typedef struct packed {
        state_e            state;
        logic              sel;
        logic [1:0]        mode;
        logic [IDX_W-1:0]  pidx;
        logic              cpu_rdy;
        logic              xm_rdy;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t q, d;

    logic              cur_sel;
    logic [ADDR_W-1:0] a_addr;
    logic              a_we;
    logic [DATA_W-1:0] a_wdata;
    logic [IDX_W-1:0]  a_idx;
    logic [TAG_W-1:0]  a_tag;
    logic              a_in_dram;
    logic              a_is_ctrl;
    logic              a_ctrl;
    logic              a_hit;
    logic              a_alloc;
    logic              go;
    logic              purging;
    logic              serving_xm;

    logic [IDX_W-1:0]  r_idx;
    logic [TAG_W-1:0]  r_tag;
    logic              r_valid;
    logic              r_dirty;
    logic [DATA_W-1:0] r_data;

    logic              s_we;
    logic [IDX_W-1:0]  s_idx;
    logic [TAG_W-1:0]  s_tag;
    logic              s_valid;
    logic              s_dirty;
    logic [DATA_W-1:0] s_data;

    // requester selection: external master wins in idle, then held
    assign cur_sel = (q.state == S_IDLE) ? xm_req : q.sel;
    assign a_addr  = cur_sel ? xm_addr  : cpu_addr;
    assign a_we    = cur_sel ? xm_we    : cpu_we;
    assign a_wdata = cur_sel ? xm_wdata : cpu_wdata;

    mcache_addr_dec #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .addr(a_addr), .idx(a_idx), .tag(a_tag),
        .in_dram(a_in_dram), .is_ctrl(a_is_ctrl)
    );

    assign purging    = (q.state == S_PSCAN) || (q.state == S_PWB);
    assign serving_xm = q.sel && (q.state != S_IDLE);
    assign r_idx      = purging ? q.pidx : a_idx;

    mcache_store #(
        .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(r_idx), .rd_tag(r_tag), .rd_valid(r_valid),
        .rd_dirty(r_dirty), .rd_data(r_data),
        .wr_en(s_we), .wr_idx(s_idx), .wr_tag(s_tag),
        .wr_valid(s_valid), .wr_dirty(s_dirty), .wr_data(s_data)
    );

    assign go      = (cpu_req || xm_req) && !q.cpu_rdy && !q.xm_rdy;
    assign a_ctrl  = !cur_sel && a_is_ctrl;
    assign a_hit   = a_in_dram && r_valid && (r_tag == a_tag);
    assign a_alloc = !cur_sel &&
                     ((q.mode == M_UNIFIED) || ((q.mode == M_INSTR) && cpu_ifetch));

    always_comb begin
        d         = q;
        d.cpu_rdy = 1'b0;
        d.xm_rdy  = 1'b0;
        s_we      = 1'b0;
        s_idx     = a_idx;
        s_tag     = a_tag;
        s_valid   = 1'b1;
        s_dirty   = 1'b0;
        s_data    = a_wdata;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {a_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_wdata = a_wdata;

        case (q.state)
            S_IDLE: begin
                if (go) begin
                    d.sel = cur_sel;
                    if (a_ctrl) begin
                        if (cpu_we) begin
                            if (cpu_wdata[1:0] != M_KEEP) d.mode = cpu_wdata[1:0];
                            if (cpu_wdata[PURGE_BIT]) begin
                                d.state = S_PSCAN;
                                d.pidx  = '0;
                            end else begin
                                d.cpu_rdy = 1'b1;
                            end
                        end else begin
                            d.rdata   = DATA_W'(q.mode);
                            d.cpu_rdy = 1'b1;
                        end
                    end else if (a_hit) begin
                        if (a_we) begin
                            s_we    = 1'b1;
                            s_dirty = 1'b1;
                        end else begin
                            d.rdata = r_data;
                        end
                        d.xm_rdy  = cur_sel;
                        d.cpu_rdy = !cur_sel;
                    end else if (a_in_dram && a_alloc) begin
                        d.state = (r_valid && r_dirty) ? S_WBACK : S_FILL;
                    end else begin
                        d.state = S_DIRECT;
                    end
                end
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {{(ADDR_W-DRAM_AW){1'b0}}, r_tag, a_idx, {OFF_W{1'b0}}};
                mem_wdata = r_data;
                if (mem_ack) d.state = S_FILL;
            end
            S_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    s_we      = 1'b1;
                    s_dirty   = a_we;
                    s_data    = a_we ? a_wdata : mem_rdata;
                    d.rdata   = mem_rdata;
                    d.cpu_rdy = 1'b1;
                    d.state   = S_IDLE;
                end
            end
            S_DIRECT: begin
                mem_req = 1'b1;
                mem_we  = a_we;
                if (mem_ack) begin
                    d.rdata   = mem_rdata;
                    d.xm_rdy  = q.sel;
                    d.cpu_rdy = !q.sel;
                    d.state   = S_IDLE;
                end
            end
            S_PSCAN, S_PWB: begin
                if (q.state == S_PWB) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = {{(ADDR_W-DRAM_AW){1'b0}}, r_tag, q.pidx, {OFF_W{1'b0}}};
                    mem_wdata = r_data;
                end
                if (q.state == S_PSCAN && r_valid && r_dirty) begin
                    d.state = S_PWB;
                end else if (q.state == S_PSCAN || mem_ack) begin
                    s_we    = 1'b1;
                    s_idx   = q.pidx;
                    s_tag   = r_tag;
                    s_valid = 1'b0;
                    s_dirty = 1'b0;
                    s_data  = r_data;
                    if (q.pidx == LAST_IDX) begin
                        d.state   = S_IDLE;
                        d.cpu_rdy = 1'b1;
                    end else begin
                        d.pidx  = q.pidx + 1'b1;
                        d.state = S_PSCAN;
                    end
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state   <= S_IDLE;
            q.sel     <= 1'b0;
            q.mode    <= M_OFF;
            q.pidx    <= '0;
            q.cpu_rdy <= 1'b0;
            q.xm_rdy  <= 1'b0;
            q.rdata   <= '0;
        end else begin
            q <= d;
        end
    end

    assign cpu_ready = q.cpu_rdy;
    assign xm_ready  = q.xm_rdy;
    assign cpu_rdata = q.rdata;
    assign xm_rdata  = q.rdata;
endmodule

// File: rtl/mcache_ctrl_chk.sv
module mcache_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              xm_ready,
    input logic [ADDR_W-1:0] xm_addr,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              purging,
    input logic              serving_xm
);
    // R12
    cpu_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R12
    xm_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xm_ready |=> !xm_ready);

    // R12
    cpu_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_ready) |-> $past(cpu_req));

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10
    xm_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serving_xm && mem_req) |-> (mem_addr[ADDR_W-1:OFF_W] == xm_addr[ADDR_W-1:OFF_W]));

    // R8
    purge_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        purging |-> !cpu_ready);
endmodule

bind mcache_ctrl mcache_ctrl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
    .xm_ready(xm_ready), .xm_addr(xm_addr), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_we(mem_we), .mem_addr(mem_addr),
    .purging(purging), .serving_xm(serving_xm)
);

// File: tb/mcache_ctrl_test.sv
module mcache_ctrl_test;
    localparam logic [31:0] CTRL = 32'hFFFF_FFF0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0, cpu_we = 1'b0, cpu_ifetch = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [127:0] cpu_wdata = '0;
    logic         cpu_ready;
    logic [127:0] cpu_rdata;
    logic         xm_req = 1'b0, xm_we = 1'b0;
    logic [31:0]  xm_addr = '0;
    logic [127:0] xm_wdata = '0;
    logic         xm_ready;
    logic [127:0] xm_rdata;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_ack = 1'b0;
    logic [127:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int cycle = 0;
    int lat = 0;

    logic [127:0] dram   [logic [31:0]];
    logic [127:0] shadow [logic [31:0]];

    always #2 clk = ~clk;

    mcache_ctrl #(.LINES(16), .CTRL_ADDR(CTRL)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ifetch(cpu_ifetch),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .xm_req(xm_req), .xm_we(xm_we), .xm_addr(xm_addr), .xm_wdata(xm_wdata),
        .xm_ready(xm_ready), .xm_rdata(xm_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [127:0] pat(input logic [31:0] a);
        return {a ^ 32'hA5A5_0000, ~a, a + 32'h1234, a[15:0], 16'hBEEF};
    endfunction

    function automatic logic [127:0] dram_of(input logic [31:0] a);
        return dram.exists(a) ? dram[a] : pat(a);
    endfunction

    function automatic logic [127:0] exp_of(input logic [31:0] a);
        return shadow.exists(a) ? shadow[a] : pat(a);
    endfunction

    // behavioural DRAM / external space, 3-cycle latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            lat = 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (lat == 2) begin
                lat = 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    dram[mem_addr] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata <= dram_of(mem_addr);
                    rd_cnt++;
                end
            end else begin
                lat++;
            end
        end
    end

    always @(posedge clk) begin
        cycle++;
        if (cycle > 50000) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp=<50000", cycle);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic ifetch, input logic [31:0] a,
                          input logic [127:0] wd, output logic [127:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_ifetch = ifetch; cpu_addr = a; cpu_wdata = wd;
        do @(negedge clk); while (!cpu_ready);
        rd = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic xm_op(input logic we, input logic [31:0] a,
                         input logic [127:0] wd, output logic [127:0] rd);
        @(negedge clk);
        xm_req = 1'b1; xm_we = we; xm_addr = a; xm_wdata = wd;
        do @(negedge clk); while (!xm_ready);
        rd = xm_rdata;
        xm_req = 1'b0;
    endtask

    // one access with data and memory-traffic checks
    task automatic acc(input string tag, input logic from_xm, input logic we,
                       input logic ifetch, input logic [31:0] a, input logic [127:0] wd,
                       input int exp_rd, input int exp_wr);
        int r0, w0;
        logic [127:0] rd;
        r0 = rd_cnt; w0 = wr_cnt;
        if (from_xm) xm_op(we, a, wd, rd);
        else cpu_op(we, ifetch, a, wd, rd);
        if (we) shadow[a] = wd;
        else chk({tag, " data"}, rd, exp_of(a));
        chk({tag, " dram reads"}, 128'(rd_cnt - r0), 128'(exp_rd));
        chk({tag, " dram writes"}, 128'(wr_cnt - w0), 128'(exp_wr));
    endtask

    task automatic ctrl_wr(input logic [7:0] v);
        logic [127:0] rd;
        cpu_op(1'b1, 1'b0, CTRL, 128'(v), rd);
    endtask

    task automatic ctrl_rd_chk(input string tag, input logic [7:0] exp);
        logic [127:0] rd;
        cpu_op(1'b0, 1'b0, CTRL, '0, rd);
        chk(tag, rd, 128'(exp));
    endtask

    task automatic t_reset;
        chk("R1 mem_req idle", 128'(mem_req), 128'(0));
        ctrl_rd_chk("R1 reset value", 8'h01);
        chk("R1 no traffic", 128'(rd_cnt + wr_cnt), 128'(0));
    endtask

    task automatic t_off;
        acc("R7 off miss", 0, 0, 0, 32'h100, '0, 1, 0);
        acc("R7 off repeat", 0, 0, 0, 32'h100, '0, 1, 0);
    endtask

    task automatic t_modes;
        ctrl_wr(8'h02);
        ctrl_rd_chk("R2 unified code", 8'h02);
        ctrl_wr(8'h7C);
        ctrl_rd_chk("R2 keep code and reserved bits", 8'h02);
    endtask

    task automatic t_unified;
        acc("R4 fill", 0, 0, 0, 32'h200, '0, 1, 0);
        acc("R4 hit", 0, 0, 0, 32'h200, '0, 0, 0);
    endtask

    task automatic t_copyback;
        acc("R5 write hit", 0, 1, 0, 32'h200, {4{32'h1111_0001}}, 0, 0);
        chk("R5 dram untouched", dram_of(32'h200), pat(32'h200));
        acc("R3 conflict evicts", 0, 0, 0, 32'h300, '0, 1, 1);
        chk("R5 written back", dram_of(32'h200), {4{32'h1111_0001}});
        acc("R3 refetch", 0, 0, 0, 32'h200, '0, 1, 0);
        acc("R3 other index", 0, 0, 0, 32'h210, '0, 1, 0);
        acc("R3 no evict", 0, 0, 0, 32'h200, '0, 0, 0);
    endtask

    task automatic t_xm_hit;
        acc("R9 cpu dirty", 0, 1, 0, 32'h200, {4{32'h2222_0002}}, 0, 0);
        acc("R9 xm read hit", 1, 0, 0, 32'h200, '0, 0, 0);
        acc("R9 xm write hit", 1, 1, 0, 32'h200, {4{32'h3333_0003}}, 0, 0);
        acc("R9 cpu sees xm", 0, 0, 0, 32'h200, '0, 0, 0);
    endtask

    task automatic t_xm_miss;
        acc("R10 xm read miss", 1, 0, 0, 32'h410, '0, 1, 0);
        acc("R10 line kept", 0, 0, 0, 32'h210, '0, 0, 0);
        acc("R10 xm write miss", 1, 1, 0, 32'h410, {4{32'h4444_0004}}, 0, 1);
        chk("R10 dram direct", dram_of(32'h410), {4{32'h4444_0004}});
        acc("R10 cpu allocates", 0, 0, 0, 32'h410, '0, 1, 0);
        acc("R10 cpu hit after", 0, 0, 0, 32'h410, '0, 0, 0);
    endtask

    task automatic t_ext;
        acc("R11 ext write", 0, 1, 0, 32'h0040_0000, {4{32'h5555_0005}}, 0, 1);
        acc("R11 ext read", 0, 0, 0, 32'h0040_0000, '0, 1, 0);
        acc("R11 ext reread", 0, 0, 0, 32'h0040_0000, '0, 1, 0);
    endtask

    task automatic t_instr;
        ctrl_wr(8'h03);
        ctrl_rd_chk("R2 instr code", 8'h03);
        acc("R6 fetch fill", 0, 0, 1, 32'h520, '0, 1, 0);
        acc("R6 fetch hit", 0, 0, 1, 32'h520, '0, 0, 0);
        acc("R6 data hit", 0, 0, 0, 32'h520, '0, 0, 0);
        acc("R6 data miss direct", 0, 0, 0, 32'h620, '0, 1, 0);
        acc("R6 fetch still hit", 0, 0, 1, 32'h520, '0, 0, 0);
        acc("R6 data write hit", 0, 1, 0, 32'h520, {4{32'h6666_0006}}, 0, 0);
        acc("R6 fetch sees write", 0, 0, 1, 32'h520, '0, 0, 0);
        acc("R6 data write miss", 0, 1, 0, 32'h720, {4{32'h7777_0007}}, 0, 1);
        acc("R6 no alloc on miss", 0, 0, 1, 32'h520, '0, 0, 0);
    endtask

    task automatic t_purge;
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        ctrl_wr(8'h82);
        chk("R8 purge writes", 128'(wr_cnt - w0), 128'(2));
        chk("R8 purge reads", 128'(rd_cnt - r0), 128'(0));
        chk("R8 dirty 0x200", dram_of(32'h200), {4{32'h3333_0003}});
        chk("R8 dirty 0x520", dram_of(32'h520), {4{32'h6666_0006}});
        ctrl_rd_chk("R8 purge bit clear", 8'h02);
        acc("R8 invalid 0x200", 0, 0, 0, 32'h200, '0, 1, 0);
        acc("R8 invalid 0x410", 0, 0, 0, 32'h410, '0, 1, 0);
    endtask

    task automatic t_priority;
        int t_cpu = 0, t_xm = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_ifetch = 1'b0; cpu_addr = 32'hA00;
        xm_req = 1'b1; xm_we = 1'b0; xm_addr = 32'h900;
        fork
            begin
                do @(negedge clk); while (!cpu_ready);
                t_cpu = cycle;
                chk("R12 cpu data", cpu_rdata, exp_of(32'hA00));
                cpu_req = 1'b0;
            end
            begin
                do @(negedge clk); while (!xm_ready);
                t_xm = cycle;
                chk("R12 xm data", xm_rdata, exp_of(32'h900));
                xm_req = 1'b0;
            end
        join
        chk("R12 xm served first", 128'(t_xm < t_cpu), 128'(1));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_modes();
        t_unified();
        t_copyback();
        t_xm_hit();
        t_xm_miss();
        t_ext();
        t_instr();
        t_purge();
        t_priority();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule